// File: doc/BRIEF.md
# Masked Interrupt Pending Selector

This block keeps one pending flag for each of four processor exception sources: normal interrupt, fast interrupt, asynchronous abort and reset. Sources are posted and cleared with a type number and an index. A clear-all strobe empties every flag at once. From the registered flags and the processor's three current mask bits, the block decides whether an exception should be taken now and which one. It reports that choice as a small cause code.

A snapshot port always shows the packed pending vector. A load strobe writes a saved vector back exactly, so the state can be saved and restored around a checkpoint. Requests with a bad type number or a nonzero index are refused without touching the flags. They raise a sticky error flag, which software-side logic clears with a dedicated pulse.

Top module: `irq_pend_sel`

## Requirements
- R1: A synchronous active-high reset leaves every pending flag at 0, the error flag at 0, take at 0 and cause at 0 from the next clock edge on.
- R2: A legal post sets one pending flag. Type 0 is IRQ, 1 is FIQ, 2 is asynchronous abort and 3 is reset, and only index 0 is legal. Flag n sits at bit n of the snapshot output.
- R3: A legal clear zeroes the flag of its type. When a post and a clear name the same type in one cycle, the flag ends up set.
- R4: Clear-all zeroes every pending flag and overrides any post in the same cycle.
- R5: A post or clear with type above 3 or a nonzero index leaves every flag unchanged and sets the error flag. The error flag stays set until err_clr is pulsed, and a new error in the same cycle as err_clr leaves it set.
- R6: mask_i blocks IRQ, mask_f blocks FIQ and mask_a blocks the abort. Reset is never blocked. A pending source whose mask is set yields cause 0 if nothing else is eligible.
- R7: Among eligible sources the order is IRQ, FIQ, abort, reset. Cause reads 1 for IRQ, 2 for FIQ, 3 for asynchronous external abort, 4 for reset and 0 for none. Cause is 0 whenever no flag is pending, whatever the masks.
- R8: take is 1 exactly when cause is nonzero. Both follow a change of the mask inputs in the same cycle, without waiting for a clock edge.
- R9: snap_load writes snap_in into the flags at the next edge. It overrides post, clear and clear-all in that cycle. Requests in a load cycle are discarded and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post request strobe |
| post_type | input | TYPE_W | Source type of the post |
| post_idx | input | IDX_W | Index of the post, must be 0 |
| clr_vld | input | 1 | Clear request strobe |
| clr_type | input | TYPE_W | Source type of the clear |
| clr_idx | input | IDX_W | Index of the clear, must be 0 |
| clr_all | input | 1 | Zero all pending flags |
| err_clr | input | 1 | Clear the sticky error flag |
| mask_i | input | 1 | IRQ mask bit |
| mask_f | input | 1 | FIQ mask bit |
| mask_a | input | 1 | Abort mask bit |
| snap_load | input | 1 | Restore strobe |
| snap_in | input | 4 | Pending vector to restore |
| snap_out | output | 4 | Current pending vector |
| take | output | 1 | An eligible source is pending |
| cause | output | 3 | Selected source code |
| err | output | 1 | Sticky illegal-request flag |

## Verification
The bench aims at collisions on one edge, because that is where an ordering mistake shows:
- A post and a clear on the same type. A design that lets the clear win drops a posted interrupt.
- Clear-all together with a post. If the post wins here, a stale flag survives the flush.
- A restore together with every other request. If the restore does not win, or if the discarded requests raise an error, the restored state is corrupted.

Illegal types and nonzero indices are checked so that they never disturb a flag, and the error flag is checked so that it survives a clear pulse that coincides with a fresh error. Masks are changed between edges, with sources of every priority pending, to catch a registered or misordered selection. Reset is checked as the one source that stays eligible under all masks.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int NUM_SRC = 4;
  localparam int CAUSE_W = 3;

  localparam int SRC_IRQ = 0;
  localparam int SRC_FIQ = 1;
  localparam int SRC_ABT = 2;
  localparam int SRC_RST = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_IRQ   = 3'd1,
    CAUSE_FIQ   = 3'd2,
    CAUSE_ABORT = 3'd3,
    CAUSE_RESET = 3'd4
  } cause_e;
endpackage

// File: rtl/irq_req_check.sv
module irq_req_check
  import irq_sel_pkg::*;
#(
  parameter int TYPE_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic               vld_i,
  input  logic [TYPE_W-1:0]  type_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [NUM_SRC-1:0] hit_o,
  output logic               bad_o
);
  logic in_range;
  logic idx_zero;

  assign in_range = (int'(type_i) < NUM_SRC);
  assign idx_zero = (idx_i == '0);
  assign bad_o    = vld_i && !(in_range && idx_zero);

  // One decoded strobe per source; only legal requests reach the flags.
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_hit
    assign hit_o[b] = vld_i && idx_zero && (type_i == TYPE_W'(b));
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [NUM_SRC-1:0] load_data_i,
  input  logic               wipe_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  // Per flag: restore, then wipe, then set, then clear.
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              pend_o[b] <= 1'b0;
      else if (load_i)      pend_o[b] <= load_data_i[b];
      else if (wipe_i)      pend_o[b] <= 1'b0;
      else if (set_i[b])    pend_o[b] <= 1'b1;
      else if (clr_i[b])    pend_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_err_flag.sv
module irq_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic suppress_i,
  input  logic bad_i,
  input  logic ack_i,
  output logic err_o
);
  always_ff @(posedge clk) begin
    if (rst)                        err_o <= 1'b0;
    else if (bad_i && !suppress_i)  err_o <= 1'b1;
    else if (ack_i)                 err_o <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_sel_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               mask_i,
  input  logic               mask_f,
  input  logic               mask_a,
  output cause_e             cause_o,
  output logic               take_o
);
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    elig          = pend_i;
    elig[SRC_IRQ] = pend_i[SRC_IRQ] && !mask_i;
    elig[SRC_FIQ] = pend_i[SRC_FIQ] && !mask_f;
    elig[SRC_ABT] = pend_i[SRC_ABT] && !mask_a;
  end

  always_comb begin
    cause_o = CAUSE_NONE;
    if (pend_i != '0) begin
      if (elig[SRC_IRQ])      cause_o = CAUSE_IRQ;
      else if (elig[SRC_FIQ]) cause_o = CAUSE_FIQ;
      else if (elig[SRC_ABT]) cause_o = CAUSE_ABORT;
      else if (elig[SRC_RST]) cause_o = CAUSE_RESET;
    end
  end

  assign take_o = (cause_o != CAUSE_NONE);
endmodule

// File: rtl/irq_pend_sel.sv
module irq_pend_sel
  import irq_sel_pkg::*;
#(
  parameter int TYPE_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [TYPE_W-1:0]  post_type,
  input  logic [IDX_W-1:0]   post_idx,
  input  logic               clr_vld,
  input  logic [TYPE_W-1:0]  clr_type,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               clr_all,
  input  logic               err_clr,
  input  logic               mask_i,
  input  logic               mask_f,
  input  logic               mask_a,
  input  logic               snap_load,
  input  logic [NUM_SRC-1:0] snap_in,
  output logic [NUM_SRC-1:0] snap_out,
  output logic               take,
  output logic [CAUSE_W-1:0] cause,
  output logic               err
);
  logic [NUM_SRC-1:0] post_hit, clr_hit;
  logic               post_bad, clr_bad;
  cause_e             sel;

  irq_req_check #(.TYPE_W(TYPE_W), .IDX_W(IDX_W)) u_post_chk (
    .vld_i(post_vld), .type_i(post_type), .idx_i(post_idx),
    .hit_o(post_hit), .bad_o(post_bad)
  );

  irq_req_check #(.TYPE_W(TYPE_W), .IDX_W(IDX_W)) u_clr_chk (
    .vld_i(clr_vld), .type_i(clr_type), .idx_i(clr_idx),
    .hit_o(clr_hit), .bad_o(clr_bad)
  );

  irq_pend_bank u_bank (
    .clk(clk), .rst(rst),
    .load_i(snap_load), .load_data_i(snap_in),
    .wipe_i(clr_all), .set_i(post_hit), .clr_i(clr_hit),
    .pend_o(snap_out)
  );

  irq_err_flag u_err (
    .clk(clk), .rst(rst),
    .suppress_i(snap_load), .bad_i(post_bad || clr_bad),
    .ack_i(err_clr), .err_o(err)
  );

  irq_prio_pick u_pick (
    .pend_i(snap_out), .mask_i(mask_i), .mask_f(mask_f), .mask_a(mask_a),
    .cause_o(sel), .take_o(take)
  );

  assign cause = sel;
endmodule

// File: rtl/irq_pend_sel_chk.sv
module irq_pend_sel_chk #(
  parameter int TYPE_W = 3,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              post_vld,
  input logic [TYPE_W-1:0] post_type,
  input logic [IDX_W-1:0]  post_idx,
  input logic              clr_vld,
  input logic              clr_all,
  input logic              err_clr,
  input logic              mask_i,
  input logic              snap_load,
  input logic [3:0]        snap_in,
  input logic [3:0]        snap_out,
  input logic              take,
  input logic [2:0]        cause,
  input logic              err
);
  logic post_illegal;
  assign post_illegal = post_vld && ((int'(post_type) > 3) || (post_idx != '0));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (snap_out == 4'd0 && !err));

  a_r4_wipe: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !snap_load) |=> snap_out == 4'd0);

  a_r5_illegal_hold: assert property (@(posedge clk) disable iff (rst)
    (post_illegal && !clr_vld && !clr_all && !snap_load)
      |=> (snap_out == $past(snap_out) && err));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);

  a_r6_reset_unblocked: assert property (@(posedge clk) disable iff (rst)
    snap_out[3] |-> take);

  a_r7_irq_first: assert property (@(posedge clk) disable iff (rst)
    (snap_out[0] && !mask_i) |-> cause == 3'd1);

  a_r8_take_cause: assert property (@(posedge clk) disable iff (rst)
    take == (cause != 3'd0));

  a_r9_restore: assert property (@(posedge clk) disable iff (rst)
    snap_load |=> snap_out == $past(snap_in));
endmodule

bind irq_pend_sel irq_pend_sel_chk #(.TYPE_W(TYPE_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .post_vld(post_vld), .post_type(post_type),
  .post_idx(post_idx), .clr_vld(clr_vld), .clr_all(clr_all),
  .err_clr(err_clr), .mask_i(mask_i), .snap_load(snap_load),
  .snap_in(snap_in), .snap_out(snap_out), .take(take), .cause(cause),
  .err(err)
);

// File: tb/irq_pend_sel_test.sv
`timescale 1ns/1ps
module irq_pend_sel_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       post_vld = 0, clr_vld = 0, clr_all = 0, err_clr = 0;
  logic [2:0] post_type = 0, clr_type = 0;
  logic [1:0] post_idx = 0, clr_idx = 0;
  logic       mask_i = 0, mask_f = 0, mask_a = 0, snap_load = 0;
  logic [3:0] snap_in = 0;
  logic [3:0] snap_out;
  logic       take, err;
  logic [2:0] cause;

  int checks = 0;
  int errors = 0;
  logic [3:0] pm = 0;
  logic       em = 0;

  always #2.5 clk = ~clk;

  irq_pend_sel uut (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_type(post_type),
    .post_idx(post_idx), .clr_vld(clr_vld), .clr_type(clr_type),
    .clr_idx(clr_idx), .clr_all(clr_all), .err_clr(err_clr),
    .mask_i(mask_i), .mask_f(mask_f), .mask_a(mask_a),
    .snap_load(snap_load), .snap_in(snap_in), .snap_out(snap_out),
    .take(take), .cause(cause), .err(err)
  );

  function automatic bit legal(logic v, logic [2:0] t, logic [1:0] i);
    return v && (t < 3'd4) && (i == 2'd0);
  endfunction

  function automatic int exp_cause(logic [3:0] p, logic mi, logic mf, logic ma);
    if (p == 4'd0)       return 0;
    if (p[0] && !mi)     return 1;
    if (p[1] && !mf)     return 2;
    if (p[2] && !ma)     return 3;
    if (p[3])            return 4;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    post_vld = 0; clr_vld = 0; clr_all = 0; err_clr = 0; snap_load = 0;
    post_idx = 0; clr_idx = 0;
  endtask

  task automatic model_step();
    bit bad;
    if (rst) begin pm = 0; em = 0; return; end
    bad = (post_vld && !legal(1'b1, post_type, post_idx)) ||
          (clr_vld && !legal(1'b1, clr_type, clr_idx));
    if (snap_load) pm = snap_in;
    else if (clr_all) pm = 0;
    else begin
      if (legal(clr_vld, clr_type, clr_idx))   pm[clr_type[1:0]] = 1'b0;
      if (legal(post_vld, post_type, post_idx)) pm[post_type[1:0]] = 1'b1;
    end
    if (!snap_load && bad) em = 1'b1;
    else if (err_clr)      em = 1'b0;
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 pending vector", snap_out, pm);
    chk("R5 error flag", err, em);
    chk("R7 cause", cause, exp_cause(pm, mask_i, mask_f, mask_a));
    chk("R8 take", take, exp_cause(pm, mask_i, mask_f, mask_a) != 0);
  endtask

  task automatic post(input logic [2:0] t, input logic [1:0] i);
    idle(); post_vld = 1; post_type = t; post_idx = i; cyc(); idle();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; cyc(); cyc();
    chk("R1 reset pending", snap_out, 0);
    chk("R1 reset err", err, 0);
    chk("R1 reset take", take, 0);
    rst = 0; cyc();

    // R6: reset source passes all masks, abort blocked by mask_a
    mask_i = 1; mask_f = 1; mask_a = 1;
    post(3'd3, 2'd0);
    chk("R6 reset unmasked", cause, 4);
    post(3'd2, 2'd0);
    chk("R6 abort masked", cause, 4);
    mask_a = 0; #1;
    chk("R8 mask drop same cycle", cause, 3);
    post(3'd0, 2'd0);
    chk("R6 irq masked", cause, 3);
    mask_i = 0; #1;
    chk("R7 irq highest", cause, 1);
    chk("R8 take follows", take, 1);

    // R3: post beats clear on one type; a lone clear removes the flag
    idle(); post_vld = 1; post_type = 0; clr_vld = 1; clr_type = 0; cyc(); idle();
    chk("R3 post wins", snap_out[0], 1);
    idle(); clr_vld = 1; clr_type = 0; cyc(); idle();
    chk("R3 clear", snap_out[0], 0);

    // R4: clear-all beats a post
    idle(); clr_all = 1; post_vld = 1; post_type = 1; cyc(); idle();
    chk("R4 wipe beats post", snap_out, 0);
    chk("R7 none when empty", cause, 0);

    // R5: illegal type and index
    post(3'd1, 2'd0);
    post(3'd5, 2'd0);
    chk("R5 bad type no change", snap_out, 4'b0010);
    chk("R5 err set", err, 1);
    idle(); err_clr = 1; cyc(); idle();
    chk("R5 err cleared", err, 0);
    post(3'd2, 2'd1);
    chk("R5 bad index no change", snap_out, 4'b0010);
    idle(); err_clr = 1; clr_vld = 1; clr_type = 3'd7; cyc(); idle();
    chk("R5 new error beats clear", err, 1);
    idle(); err_clr = 1; cyc(); idle();

    // R9: restore beats everything, discarded requests raise no error
    idle(); snap_load = 1; snap_in = 4'b1010; clr_all = 1;
    post_vld = 1; post_type = 3'd6; clr_vld = 1; clr_type = 1; cyc(); idle();
    chk("R9 restore exact", snap_out, 4'b1010);
    chk("R9 no error in load", err, 0);
    mask_f = 0; #1;
    chk("R7 fiq over reset", cause, 2);

    // R1 again mid-run
    rst = 1; cyc(); rst = 0;
    chk("R1 reset mid-run", snap_out, 0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      idle();
      post_vld  = ($urandom % 2) == 0;
      post_type = 3'($urandom % 6);
      post_idx  = (($urandom % 10) == 0) ? 2'd1 : 2'd0;
      clr_vld   = ($urandom % 3) == 0;
      clr_type  = 3'($urandom % 6);
      clr_idx   = (($urandom % 10) == 0) ? 2'd2 : 2'd0;
      clr_all   = ($urandom % 20) == 0;
      err_clr   = ($urandom % 8) == 0;
      snap_load = ($urandom % 20) == 0;
      snap_in   = 4'($urandom);
      mask_i    = ($urandom % 3) == 0;
      mask_f    = ($urandom % 3) == 0;
      mask_a    = ($urandom % 3) == 0;
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule